// File: doc/BRIEF.md
# AC Power Gate with Hysteresis

This block watches a stream of signed ADC samples and decides whether a background interleave calibration loop may keep refining its sample-timing-skew estimate. Each accepted sample is left-aligned into a 12-bit field and squared. The squares are summed over a fixed power-of-two window, and the sum is scaled down to an average power figure. When a window completes, the average is compared with a programmed threshold. The result moves a two-state machine between Track and Hold, with a wider margin required to leave Hold than to enter it.

The threshold and the hysteresis margin are loaded over a simple byte-wide register bus. The hysteresis is an ordinary register. The two threshold bytes are write-protected. They accept data only after an unlock key has been written to a page-select register. Three registered enables leave the block, one for each estimator. Only the skew enable follows the Track/Hold state. The offset and gain enables stay high.

Top module: `ac_power_gate`

## Requirements
- R1: A sample of IN_W bits (two's complement, IN_W <= 12) is padded with zeros below its LSB to 12 bits and squared as a signed value into a 24-bit non-negative result; -2048 yields 0x400000.
- R2: Squares are summed over 2^WIN_LOG2 samples that have smp_valid high. Cycles with smp_valid low add nothing. The average is the window sum shifted right by WIN_LOG2, and the sum restarts from zero for the next window.
- R3: Each completed window produces one single-cycle decision_valid pulse, and avg_power holds that window's average from that cycle on.
- R4: The threshold word is {4'b0, T[15:8], T[7:0], 4'b0}. T[15:8] is written at address 0x150 and T[7:0] at address 0x14F. Both writes take effect only while the page register at address 0x10 holds 0x80; otherwise they are ignored.
- R5: The hysteresis word is {12'b0, H, 4'b0}, where H is the byte written at address 0x55, with no page condition.
- R6: After reset the block is in Track, all three enables are high, decision_valid is low, and the threshold, hysteresis and page registers are zero.
- R7: In Track, a decision whose average is strictly below the threshold word moves the block to Hold. An average equal to the threshold keeps it in Track.
- R8: In Hold, a decision moves the block to Track only if the average is at least threshold word plus hysteresis word (a 25-bit sum). Otherwise it stays in Hold.
- R9: en_skew is high exactly when the block is in Track. en_offset and en_gain stay high in both states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | IN_W | Signed sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 8 | Register write data |
| decision_valid | output | 1 | One-cycle pulse per completed window |
| avg_power | output | 24 | Average power of the last window |
| in_track | output | 1 | 1 = Track, 0 = Hold |
| en_offset | output | 1 | Offset estimate update enable |
| en_gain | output | 1 | Gain estimate update enable |
| en_skew | output | 1 | Skew estimate update enable |

## Verification
The assertions compare each state change with the threshold and hysteresis words as they stand when the decision is registered. They therefore assume that no register write lands while a window is being closed. The stimulus does all register writes between windows, while the sample strobe is idle. The assertions also assume a window of at least two samples, so decisions can never arrive back to back. The bench sweeps sample amplitudes across the whole 12-bit range, including the most negative code, and mixes in idle gaps. A narrower instance exercises the alignment.

// File: rtl/apg_pkg.sv
package apg_pkg;
  localparam int ALIGN_W  = 12;
  localparam int SQ_W     = 2 * ALIGN_W;
  localparam int ADDR_W   = 9;
  localparam int DATA_W   = 8;

  localparam logic [ADDR_W-1:0] A_PAGE   = 9'h010;
  localparam logic [ADDR_W-1:0] A_HYST   = 9'h055;
  localparam logic [ADDR_W-1:0] A_THR_LO = 9'h14F;
  localparam logic [ADDR_W-1:0] A_THR_HI = 9'h150;
  localparam logic [DATA_W-1:0] PAGE_KEY = 8'h80;

  typedef enum logic {ST_TRACK = 1'b0, ST_HOLD = 1'b1} gate_state_t;
endpackage

// File: rtl/apg_regs.sv
module apg_regs
  import apg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SQ_W-1:0]   thr_word,
  output logic [SQ_W-1:0]   hyst_word
);
  logic [DATA_W-1:0] page_q;
  logic [DATA_W-1:0] thr_hi_q;
  logic [DATA_W-1:0] thr_lo_q;
  logic [DATA_W-1:0] hyst_q;
  logic              unlocked;

  assign unlocked = (page_q == PAGE_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      thr_hi_q <= '0;
      thr_lo_q <= '0;
      hyst_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PAGE:   page_q <= wr_data;
        A_HYST:   hyst_q <= wr_data;
        A_THR_HI: if (unlocked) thr_hi_q <= wr_data;
        A_THR_LO: if (unlocked) thr_lo_q <= wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    thr_word  = {4'b0000, thr_hi_q, thr_lo_q, 4'b0000};
    hyst_word = {12'h000, hyst_q, 4'b0000};
  end
endmodule

// File: rtl/apg_square.sv
module apg_square
  import apg_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            sq_valid,
  output logic [SQ_W-1:0] sq_data
);
  localparam int PAD_W = ALIGN_W - IN_W;

  logic signed [ALIGN_W-1:0] aligned;
  logic signed [SQ_W-1:0]    product;

  generate
    if (PAD_W == 0) begin : g_full
      assign aligned = in_data;
    end else begin : g_pad
      assign aligned = {in_data, {PAD_W{1'b0}}};
    end
  endgenerate

  assign product = aligned * aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid <= 1'b0;
      sq_data  <= '0;
    end else begin
      sq_valid <= in_valid;
      if (in_valid) sq_data <= product;
    end
  end
endmodule

// File: rtl/apg_accum.sv
module apg_accum
  import apg_pkg::*;
#(
  parameter int WIN_LOG2 = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sq_valid,
  input  logic [SQ_W-1:0] sq_data,
  output logic            avg_valid,
  output logic [SQ_W-1:0] avg_data
);
  localparam int ACC_W = SQ_W + WIN_LOG2;
  localparam logic [WIN_LOG2-1:0] LAST = {WIN_LOG2{1'b1}};

  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    sum_next;
  logic [WIN_LOG2-1:0] cnt_q;

  assign sum_next = acc_q + {{WIN_LOG2{1'b0}}, sq_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      avg_valid <= 1'b0;
      avg_data  <= '0;
    end else begin
      avg_valid <= 1'b0;
      if (sq_valid) begin
        if (cnt_q == LAST) begin
          avg_data  <= sum_next[ACC_W-1:WIN_LOG2];
          avg_valid <= 1'b1;
          acc_q     <= '0;
          cnt_q     <= '0;
        end else begin
          acc_q <= sum_next;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/apg_hyst_fsm.sv
module apg_hyst_fsm
  import apg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            avg_valid,
  input  logic [SQ_W-1:0] avg_data,
  input  logic [SQ_W-1:0] thr_word,
  input  logic [SQ_W-1:0] hyst_word,
  output logic            dec_valid,
  output logic [SQ_W-1:0] dec_power,
  output logic            tracking
);
  gate_state_t state_q, state_d;
  logic [SQ_W:0] rearm_level;

  assign rearm_level = {1'b0, thr_word} + {1'b0, hyst_word};

  always_comb begin
    state_d = state_q;
    if (avg_valid) begin
      case (state_q)
        ST_TRACK: if (avg_data < thr_word) state_d = ST_HOLD;
        ST_HOLD:  if ({1'b0, avg_data} >= rearm_level) state_d = ST_TRACK;
        default:  state_d = ST_TRACK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_TRACK;
      dec_valid <= 1'b0;
      dec_power <= '0;
      tracking  <= 1'b1;
    end else begin
      state_q   <= state_d;
      dec_valid <= avg_valid;
      tracking  <= (state_d == ST_TRACK);
      if (avg_valid) dec_power <= avg_data;
    end
  end
endmodule

// File: rtl/ac_power_gate.sv
module ac_power_gate
  import apg_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int WIN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [IN_W-1:0]   smp_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              decision_valid,
  output logic [SQ_W-1:0]   avg_power,
  output logic              in_track,
  output logic              en_offset,
  output logic              en_gain,
  output logic              en_skew
);
  logic [SQ_W-1:0] thr_word;
  logic [SQ_W-1:0] hyst_word;
  logic            sq_valid;
  logic [SQ_W-1:0] sq_data;
  logic            avg_valid;
  logic [SQ_W-1:0] avg_data;
  logic            tracking;

  apg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .thr_word(thr_word), .hyst_word(hyst_word)
  );

  apg_square #(.IN_W(IN_W)) u_square (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_data(smp_data),
    .sq_valid(sq_valid), .sq_data(sq_data)
  );

  apg_accum #(.WIN_LOG2(WIN_LOG2)) u_accum (
    .clk(clk), .rst(rst), .sq_valid(sq_valid), .sq_data(sq_data),
    .avg_valid(avg_valid), .avg_data(avg_data)
  );

  apg_hyst_fsm u_fsm (
    .clk(clk), .rst(rst), .avg_valid(avg_valid), .avg_data(avg_data),
    .thr_word(thr_word), .hyst_word(hyst_word),
    .dec_valid(decision_valid), .dec_power(avg_power), .tracking(tracking)
  );

  assign in_track = tracking;
  assign en_skew  = tracking;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_offset <= 1'b1;
      en_gain   <= 1'b1;
    end else begin
      en_offset <= 1'b1;
      en_gain   <= 1'b1;
    end
  end
endmodule

// File: rtl/apg_checker.sv
module apg_checker (
  input logic        clk,
  input logic        rst,
  input logic        decision_valid,
  input logic [23:0] avg_power,
  input logic        in_track,
  input logic        en_offset,
  input logic        en_gain,
  input logic        en_skew,
  input logic [23:0] thr_word,
  input logic [23:0] hyst_word
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    decision_valid |=> !decision_valid);

  p_state_moves_on_decision_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(in_track) |-> decision_valid);

  p_enter_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(in_track) |-> (avg_power < thr_word));

  p_stay_track_r7: assert property (@(posedge clk) disable iff (rst)
    (decision_valid && $past(in_track) && avg_power >= thr_word) |-> in_track);

  p_leave_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(in_track) |-> ({1'b0, avg_power} >= ({1'b0, thr_word} + {1'b0, hyst_word})));

  p_skew_follows_r9: assert property (@(posedge clk) disable iff (rst)
    en_skew == in_track);

  p_others_on_r9: assert property (@(posedge clk) disable iff (rst)
    en_offset && en_gain);
endmodule

bind ac_power_gate apg_checker u_chk (
  .clk(clk), .rst(rst), .decision_valid(decision_valid), .avg_power(avg_power),
  .in_track(in_track), .en_offset(en_offset), .en_gain(en_gain), .en_skew(en_skew),
  .thr_word(thr_word), .hyst_word(hyst_word)
);

// File: tb/tb_ac_power_gate.sv
module tb_ac_power_gate;
  localparam int WL = 2;
  localparam int WIN = 1 << WL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [9:0]  smp_narrow = '0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;

  logic        dv, dv_n, trk, trk_n, eo, eg, es, eo_n, eg_n, es_n;
  logic [23:0] avg, avg_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ac_power_gate #(.IN_W(12), .WIN_LOG2(WL)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .decision_valid(dv), .avg_power(avg), .in_track(trk),
    .en_offset(eo), .en_gain(eg), .en_skew(es)
  );

  ac_power_gate #(.IN_W(10), .WIN_LOG2(WL)) dut_narrow (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_narrow),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .decision_valid(dv_n), .avg_power(avg_n), .in_track(trk_n),
    .en_offset(eo_n), .en_gain(eg_n), .en_skew(es_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sq12(input int v);
    logic [11:0] b = v[11:0];
    int s = $signed(b);
    return longint'(s) * longint'(s);
  endfunction

  function automatic longint sq10(input int v);
    logic [9:0] b = v[9:0];
    int s = $signed(b);
    s = s * 4;
    return longint'(s) * longint'(s);
  endfunction

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Feeds one window; gap inserts idle cycles between samples.
  task automatic window(input int v0, input int v1, input int v2, input int v3,
                        input bit gap, input string tag);
    int vs [4];
    longint e12 = 0, e10 = 0;
    bit seen = 0;
    vs[0] = v0; vs[1] = v1; vs[2] = v2; vs[3] = v3;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = vs[i][11:0];
      smp_narrow = vs[i][9:0];
      e12 += sq12(vs[i]);
      e10 += sq10(vs[i]);
      if (gap) begin
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data = 12'hFFF;
        @(negedge clk);
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    for (int w = 0; w < 8 && !seen; w++) begin
      if (dv) seen = 1;
      else @(negedge clk);
    end
    chk(seen, {tag, " R3 decision pulse"}, seen, 1);
    chk(avg == 24'(e12 >> WL), {tag, " R1/R2 average"}, avg, e12 >> WL);
    chk(avg_n == 24'(e10 >> WL), {tag, " R1 narrow alignment"}, avg_n, e10 >> WL);
    @(negedge clk);
    chk(!dv, {tag, " R3 single cycle"}, dv, 0);
  endtask

  task automatic state_is(input bit exp_trk, input string tag);
    chk(trk == exp_trk, {tag, " state"}, trk, exp_trk);
    chk(es == exp_trk, {tag, " R9 en_skew"}, es, exp_trk);
    chk(eo && eg, {tag, " R9 offset/gain on"}, {eo, eg}, 3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk(trk && eo && eg && es && !dv, "R6 reset outputs", {trk, eo, eg, es, dv}, 5'b11110);

    // R6: threshold starts at zero, so zero power never forces Hold
    window(0, 0, 0, 0, 0, "R6 zero thr");
    state_is(1, "R6 still track");

    // R4 locked page: writes ignored
    wr(9'h150, 8'h01);
    window(1, 1, 1, 1, 0, "R4 locked");
    state_is(1, "R4 locked write ignored");

    // Unlock and load threshold 0x0100 -> word 4096; R5 hysteresis 0x10 -> 256
    wr(9'h010, 8'h80);
    wr(9'h150, 8'h01);
    wr(9'h14F, 8'h00);
    wr(9'h055, 8'h10);

    window(64, -64, 64, -64, 0, "R7 equal");
    state_is(1, "R7 equal keeps track");
    window(60, 60, -60, 60, 1, "R7 below");
    state_is(0, "R7 enter hold");
    window(65, 65, 65, 65, 0, "R8 under margin");
    state_is(0, "R8 stays hold");
    window(66, -66, 66, 66, 1, "R8 over margin");
    state_is(1, "R8 back to track");
    window(63, 63, 63, 63, 0, "R7 below again");
    state_is(0, "R7 hold again");

    // R4: relock, then a write to the high byte must not raise the threshold
    wr(9'h010, 8'h00);
    wr(9'h150, 8'hFF);
    window(66, 66, 66, 66, 0, "R4 relocked");
    state_is(1, "R4 relocked high byte ignored");

    // R5: hysteresis 0xFF -> 4080; rearm at 8176
    wr(9'h055, 8'hFF);
    window(10, 10, 10, 10, 0, "R5 drop");
    state_is(0, "R5 hold");
    window(90, 90, 90, 90, 0, "R5 8100");
    state_is(0, "R5 below 8176");
    window(91, 91, 91, 91, 0, "R5 8281");
    state_is(1, "R5 above 8176");

    // R1/R2 sweep across the full range, including -2048
    for (int v = -2048; v < 2048; v += 41) window(v, -v - 1, v, 2047, 0, "R1 sweep");
    window(-2048, -2048, -2048, -2048, 0, "R1 most negative");
    chk(avg == 24'h400000, "R1 -2048 square", avg, 24'h400000);
    window(-2048, 2047, 1, 0, 1, "R2 mixed gaps");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule